// File: doc/BRIEF.md
# Byte-Write Mode Selecting Controller

This block accepts single-byte write requests and turns each into the least costly operation on a nonvolatile byte array that can erase a byte (all bits to one) and program a byte (clearing bits to zero) as separate steps. Before each access it waits for any programming still in progress to finish. It then reads the stored byte for a fixed number of cycles and forms a difference mask (stored XOR requested). From that mask it picks one of four outcomes: erase followed by program, erase alone, program alone, or no operation at all.

When an operation is needed, the controller first arms the array together with the chosen mode, and starts it on the next cycle. A timer then keeps `busy` high for the programming time. The combined mode takes the full time and the single-step modes take half of it. A requester that presents a new request while the controller is working sees `req_ready` low and keeps its request until it is taken.

The state machine has six states. IDLE accepts a request and moves to WAIT. WAIT stays until the timer has expired, then moves to READ. READ drives the read strobe for the read-stall count and latches the stored byte, then moves to DECIDE. DECIDE returns to IDLE when the bytes match and otherwise moves to ARM. ARM drives the arm strobe and mode, then moves to START. START drives the start strobe, loads the timer and returns to IDLE.

Top module: `ee_wmode_ctrl`

## Requirements
- R1: No read of the array is issued while a previous programming time is still running; a new request accepted during that time waits in WAIT.
- R2: Each access reads the stored byte with `mem_rd_en` high for exactly RD_CYCLES (default 4) consecutive cycles at the requested address.
- R3: When some bit must rise (mask AND new is nonzero) and the new byte is not 8'hFF, mode 2'b00 (erase then program) is issued with `mem_wdata` equal to the new byte, and the array ends up holding the new byte.
- R4: When some bit must rise and the new byte is 8'hFF, mode 2'b01 (erase only) is issued and no data is loaded (`mem_wdata` is 8'h00).
- R5: When no bit must rise but the mask is nonzero, mode 2'b10 (program only) is issued with `mem_wdata` equal to the new byte.
- R6: When the stored and new bytes are equal, neither arm nor start is driven, and the controller returns to ready.
- R7: Launch takes two cycles: one cycle of `mem_arm` with the mode on `mem_mode`, then one cycle of `mem_start` with the same mode.
- R8: After the start cycle, `busy` stays high for PGM_CYCLES (default 16) cycles in mode 2'b00 and PGM_CYCLES/2 cycles in modes 2'b01 and 2'b10.
- R9: `req_ready` is low from the cycle after a request is taken until the controller is back in IDLE; a request presented meanwhile is held and carried out later, not dropped.
- R10: During reset `busy`, `mem_rd_en`, `mem_arm` and `mem_start` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Write request present |
| req_addr | input | 10 | Byte address of the request |
| req_data | input | 8 | Byte to store |
| req_ready | output | 1 | Controller takes a request this cycle |
| busy | output | 1 | Access or programming time in progress |
| mem_addr | output | 10 | Array address |
| mem_rd_en | output | 1 | Read strobe |
| mem_rd_data | input | 8 | Stored byte from the array |
| mem_arm | output | 1 | Arm strobe, first launch step |
| mem_start | output | 1 | Start strobe, second launch step |
| mem_mode | output | 2 | 00 erase+program, 01 erase only, 10 program only |
| mem_wdata | output | 8 | Byte to program |

## Verification
The stored/new byte pairs are chosen so that each produces one outcome. A pair where bits both rise and fall selects the combined mode. Writing 8'hFF over a byte with zeros selects erase only. Pure bit clearing selects program only. Rewriting an equal byte must produce no operation. Writing 8'h00 is also tried, because it clears bits without needing an erase. A scoreboard compares every issued mode, address and data byte against a model of the array. That model enforces erase-to-ones and program-clears-only, so a wrong mode also leaves wrong final contents. Isolated writes measure the busy length for each mode. Back-to-back writes to several addresses show that requests are held off rather than lost and that no read overlaps a running programming time.

// File: rtl/ee_wmode_pkg.sv
package ee_wmode_pkg;

    typedef enum logic [1:0] {
        MODE_ERASE_PGM = 2'b00,
        MODE_ERASE     = 2'b01,
        MODE_PGM       = 2'b10,
        MODE_NONE      = 2'b11
    } wmode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_READ,
        ST_DECIDE,
        ST_ARM,
        ST_START
    } state_e;

endpackage

// File: rtl/ee_mode_pick.sv
module ee_mode_pick
    import ee_wmode_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic [DW-1:0] old_byte,
    input  logic [DW-1:0] new_byte,
    output wmode_e        mode
);
    logic [DW-1:0] diff;
    logic          must_rise;
    logic          all_ones;

    assign diff      = old_byte ^ new_byte;
    assign must_rise = |(diff & new_byte);
    assign all_ones  = &new_byte;

    always_comb begin
        if (diff == '0)
            mode = MODE_NONE;
        else if (must_rise)
            mode = all_ones ? MODE_ERASE : MODE_ERASE_PGM;
        else
            mode = MODE_PGM;
    end
endmodule

// File: rtl/ee_pgm_timer.sv
module ee_pgm_timer #(
    parameter int FULL = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic half,
    output logic busy
);
    localparam int CW       = $clog2(FULL + 1);
    localparam int HALF_CYC = (FULL / 2 < 1) ? 1 : FULL / 2;

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= half ? CW'(HALF_CYC) : CW'(FULL);
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    AST_TMR_LOAD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> !busy); // R1
endmodule

// File: rtl/ee_wmode_ctrl.sv
module ee_wmode_ctrl
    import ee_wmode_pkg::*;
#(
    parameter int AW         = 10,
    parameter int DW         = 8,
    parameter int PGM_CYCLES = 16,
    parameter int RD_CYCLES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_data,
    output logic          req_ready,
    output logic          busy,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd_en,
    input  logic [DW-1:0] mem_rd_data,
    output logic          mem_arm,
    output logic          mem_start,
    output logic [1:0]    mem_mode,
    output logic [DW-1:0] mem_wdata
);
    localparam int RCW = $clog2(RD_CYCLES + 1);

    state_e         state, state_nx;
    logic [AW-1:0]  addr_q;
    logic [DW-1:0]  data_q;
    logic [DW-1:0]  old_q;
    wmode_e         mode_q;
    wmode_e         pick;
    logic [RCW-1:0] rd_cnt;
    logic           tmr_busy;
    logic           rd_last;

    assign rd_last = (rd_cnt == RCW'(RD_CYCLES - 1));

    ee_mode_pick #(.DW(DW)) u_pick (
        .old_byte (old_q),
        .new_byte (data_q),
        .mode     (pick)
    );

    ee_pgm_timer #(.FULL(PGM_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (state == ST_START),
        .half  (mode_q != MODE_ERASE_PGM),
        .busy  (tmr_busy)
    );

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            data_q <= '0;
            old_q  <= '0;
            mode_q <= MODE_NONE;
            rd_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && req_valid) begin
                addr_q <= req_addr;
                data_q <= req_data;
            end
            if (state == ST_WAIT)
                rd_cnt <= '0;
            else if (state == ST_READ) begin
                rd_cnt <= rd_cnt + 1'b1;
                if (rd_last)
                    old_q <= mem_rd_data;
            end
            if (state == ST_DECIDE)
                mode_q <= pick;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (req_valid) state_nx = ST_WAIT;
            ST_WAIT:   if (!tmr_busy) state_nx = ST_READ;
            ST_READ:   if (rd_last)   state_nx = ST_DECIDE;
            ST_DECIDE: state_nx = (pick == MODE_NONE) ? ST_IDLE : ST_ARM;
            ST_ARM:    state_nx = ST_START;
            ST_START:  state_nx = ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready = 1'b0;
        mem_rd_en = 1'b0;
        mem_arm   = 1'b0;
        mem_start = 1'b0;
        mem_mode  = 2'b00;
        mem_wdata = '0;
        unique case (state)
            ST_IDLE:  req_ready = 1'b1;
            ST_READ:  mem_rd_en = 1'b1;
            ST_ARM, ST_START: begin
                mem_arm   = (state == ST_ARM);
                mem_start = (state == ST_START);
                mem_mode  = mode_q;
                if (mode_q != MODE_ERASE)
                    mem_wdata = data_q;
            end
            default: ;
        endcase
    end

    assign mem_addr = addr_q;
    assign busy     = (state != ST_IDLE) || tmr_busy;

    AST_NO_READ_IN_PGM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |-> !tmr_busy); // R1
    AST_START_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> $past(mem_arm)); // R7
    AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_start |-> (mem_mode == $past(mem_mode))); // R7
    AST_ERASE_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_arm && mem_mode == 2'b01) |-> (mem_wdata == '0)); // R4
    AST_EQUAL_NO_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DECIDE && old_q == data_q) |=> !mem_arm); // R6
endmodule

// File: tb/ee_wmode_ctrl_tb_top.sv
module ee_wmode_ctrl_tb_top;
    localparam int AW  = 10;
    localparam int DW  = 8;
    localparam int PGM = 16;
    localparam int RD  = 4;
    localparam int NB  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_data = '0;
    logic          req_ready, busy, mem_rd_en, mem_arm, mem_start;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_rd_data, mem_wdata;
    logic [1:0]    mem_mode;

    always #5 clk = ~clk;

    ee_wmode_ctrl #(.AW(AW), .DW(DW), .PGM_CYCLES(PGM), .RD_CYCLES(RD)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_data(req_data), .req_ready(req_ready), .busy(busy),
        .mem_addr(mem_addr), .mem_rd_en(mem_rd_en), .mem_rd_data(mem_rd_data),
        .mem_arm(mem_arm), .mem_start(mem_start), .mem_mode(mem_mode),
        .mem_wdata(mem_wdata)
    );

    // behavioural array: erase sets ones, program only clears
    logic [DW-1:0] cells  [NB];
    logic [DW-1:0] shadow [NB];
    logic          arm_q = 1'b0;

    assign mem_rd_data = cells[mem_addr];

    always @(posedge clk) begin
        arm_q <= mem_arm;
        if (mem_start && arm_q) begin
            case (mem_mode)
                2'b00:   cells[mem_addr] <= mem_wdata;
                2'b01:   cells[mem_addr] <= '1;
                2'b10:   cells[mem_addr] <= cells[mem_addr] & mem_wdata;
                default: ;
            endcase
        end
    end

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(input logic [7:0] o, input logic [7:0] n);
        logic [7:0] d;
        d = o ^ n;
        if (d == 8'h00)            return 2'b11;
        if ((d & n) != 8'h00)      return (n == 8'hFF) ? 2'b01 : 2'b00;
        return 2'b10;
    endfunction

    // scoreboard queue: {addr, mode, data}
    logic [AW+2+DW-1:0] sbq[$];
    int  pushes = 0;
    int  starts = 0;
    bit  solo = 1'b0;

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        logic [1:0] em;
        em = exp_mode(shadow[a], d);
        if (em != 2'b11) begin
            sbq.push_back({a, em, d});
            pushes++;
        end
        shadow[a] = d;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_data  = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R9 ready low after accept", int'(req_ready), 0);
    endtask

    task automatic wait_idle();
        @(negedge clk);
        while (busy || req_valid) @(negedge clk);
        repeat (2) @(negedge clk);
    endtask

    // monitor
    int  rd_run = 0;
    int  prog_left = 0;
    bit  meas_on = 1'b0;
    int  meas_cnt = 0;
    int  meas_exp = 0;
    bit  prev_arm = 1'b0;
    logic [1:0] prev_mode = 2'b00;

    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_rd_en) begin
                rd_run++;
                if (prog_left != 0)
                    check(1'b0, "R1 read during programming", prog_left, 0);
            end else if (rd_run != 0) begin
                check(rd_run == RD, "R2 read stall length", rd_run, RD);
                rd_run = 0;
            end
            if (prog_left > 0) prog_left--;
            if (meas_on) begin
                if (busy) meas_cnt++;
                else begin
                    check(meas_cnt == meas_exp, "R8 busy length", meas_cnt, meas_exp);
                    meas_on = 1'b0;
                end
            end
            if (mem_start) begin
                logic [AW+2+DW-1:0] it;
                starts++;
                check(prev_arm, "R7 arm before start", int'(prev_arm), 1);
                check(mem_mode == prev_mode, "R7 mode held", mem_mode, prev_mode);
                if (sbq.size() == 0)
                    check(1'b0, "R6 unexpected operation", starts, pushes);
                else begin
                    it = sbq.pop_front();
                    check(mem_addr == it[AW+2+DW-1:2+DW], "R2 address", mem_addr, it[AW+2+DW-1:2+DW]);
                    case (it[DW+1:DW])
                        2'b00: begin
                            check(mem_mode == 2'b00, "R3 mode", mem_mode, 0);
                            check(mem_wdata == it[DW-1:0], "R3 data", mem_wdata, it[DW-1:0]);
                        end
                        2'b01: begin
                            check(mem_mode == 2'b01, "R4 mode", mem_mode, 1);
                            check(mem_wdata == 8'h00, "R4 no data", mem_wdata, 0);
                        end
                        default: begin
                            check(mem_mode == 2'b10, "R5 mode", mem_mode, 2);
                            check(mem_wdata == it[DW-1:0], "R5 data", mem_wdata, it[DW-1:0]);
                        end
                    endcase
                end
                prog_left = (mem_mode == 2'b00) ? PGM : PGM / 2;
                if (solo) begin
                    meas_on  = 1'b1;
                    meas_cnt = 0;
                    meas_exp = prog_left;
                end
            end
            prev_arm  = mem_arm;
            prev_mode = mem_mode;
        end
    end

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=done", 200000);
        finish_run();
    end

    initial begin
        int s0;
        for (int i = 0; i < NB; i++) begin
            cells[i]  = 8'((i * 37) & 8'hFF);
            shadow[i] = 8'((i * 37) & 8'hFF);
        end
        repeat (3) @(negedge clk);
        check(busy == 1'b0, "R10 busy in reset", busy, 0);
        check(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
        check(!mem_rd_en && !mem_arm && !mem_start, "R10 strobes in reset",
              {mem_rd_en, mem_arm, mem_start}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // isolated writes: one mode each, busy length measured
        solo = 1'b1;
        wr(10'd5, 8'h3C);  wait_idle();   // R3 (old B9)
        wr(10'd5, 8'hFF);  wait_idle();   // R4
        wr(10'd5, 8'h0F);  wait_idle();   // R5
        s0 = starts;
        wr(10'd5, 8'h0F);  wait_idle();   // R6 equal byte
        check(starts == s0, "R6 no operation on equal", starts, s0);
        check(req_ready == 1'b1 && busy == 1'b0, "R6 back to ready", req_ready, 1);
        wr(10'd5, 8'h00);  wait_idle();   // R5 clear all
        wr(10'd0, 8'h00);  wait_idle();   // R6 (old 00)
        wr(10'd1023, 8'hA5); wait_idle();

        // back-to-back writes: held off, none dropped, no overlap
        solo = 1'b0;
        wr(10'd7,  8'hFF);
        wr(10'd8,  8'h12);
        wr(10'd7,  8'h81);
        wr(10'd9,  8'h00);
        wr(10'd8,  8'h12);
        wr(10'd300, 8'hFE);
        wait_idle();
        repeat (PGM + 4) @(negedge clk);

        check(sbq.size() == 0, "R9 all requests carried out", sbq.size(), 0);
        check(starts == pushes, "R6 operation count", starts, pushes);
        begin
            int bad;
            bad = 0;
            for (int i = 0; i < NB; i++)
                if (cells[i] !== shadow[i]) bad++;
            check(bad == 0, "R3 final array contents", bad, 0);
        end
        finish_run();
    end
endmodule